// File: doc/BRIEF.md
# Host Control Register Bank with Two-Wire EEPROM Port

This block sits on a simple synchronous byte-wide host bus and answers to a window of eight consecutive byte addresses. The window sits at an aligned base taken from a configuration input. Two of the eight locations hold live state. The first sets the game-port speed. It also holds a power-down bit and the enable for an interrupt that fires on a context switch. The second lets software drive a serial EEPROM by toggling bits. It has a clock line and an open-drain data line, both gated by an interface enable, and a readback of the data pin. The same location holds the polarity of an external CD interrupt output.

The power-down bit shuts out the EEPROM location: writes there are ignored and reads return zero. Every stored value is kept, so clearing the bit restores the previous pin state. The other six locations decode but carry no state.

The bus is plain strobes. A write takes effect at the clock edge on which `wr_en` is high, and read data is combinational while `rd_en` is high. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `ctrl_regbank`

## Requirements
- R1: An access hits only when `addr[15:12]` is zero and `addr[11:3]` equals `base_addr[11:3]`; `base_addr[2:0]` is ignored and `addr[2:0]` picks the location.
- R2: Locations 2 to 7 read as 0x00, and writes to them change no output and no readable state.
- R3: Location 0 resets to 0x01 and reads back as: bits 1:0 the game-port rate (00 slowest through 11 fastest), bit 3 the power-down bit, bit 5 the context-switch interrupt enable, all other bits 0. `joy_rate` and `xtal_off` show the stored rate and power-down bit.
- R4: While the power-down bit is 1, writes to location 1 are ignored and reads of it return 0x00. Location 0 stays fully accessible, and location 1 keeps its contents.
- R5: `host_irq` is a sticky flag. It is set one cycle after a `cs_event` pulse that arrives while the enable (location 0 bit 5) is 1. A pulse while the enable is 0 leaves it unchanged.
- R6: A write to location 0 with bit 5 equal to 0 clears `host_irq` at that edge, and this wins over a `cs_event` in the same cycle.
- R7: Location 1 resets with bit 7 (CD polarity) at 1 and bits 2:0 at 0. It reads back as: bit 7 the polarity, bit 2 the data pin, bit 1 the data bit, bit 0 the clock bit, other bits 0.
- R8: `ee_scl_oe` equals the interface enable (location 1 bit 2 as written) and `ee_scl_o` equals the clock bit. The clock bit stores writes even while the enable is 0.
- R9: `ee_sda_oe` (drive the data pin low) is 1 only when the enable is 1 and the data bit is 0. Otherwise the pin is released.
- R10: A read of location 1 bit 2 returns `ee_sda_i`, not the stored enable.
- R11: `cd_int_out` equals `cd_int_req` when the polarity bit is 1 and its inverse when it is 0.
- R12: A read that misses returns 0x00, and a write that misses changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 12 | Window base; bits 2:0 ignored |
| addr | input | 16 | Host address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not reading a hit |
| cs_event | input | 1 | One-cycle context-switch event |
| host_irq | output | 1 | Sticky context-switch interrupt |
| joy_rate | output | 2 | Game-port rate |
| xtal_off | output | 1 | Power-down bit |
| ee_sda_i | input | 1 | EEPROM data pin level |
| ee_scl_o | output | 1 | EEPROM clock value |
| ee_scl_oe | output | 1 | EEPROM clock output enable |
| ee_sda_oe | output | 1 | Drive EEPROM data pin low |
| cd_int_req | input | 1 | CD interrupt request, active high |
| cd_int_out | output | 1 | CD interrupt pin with chosen polarity |

## Verification
Two functions can land on the same edge. A `cs_event` pulse can set the sticky interrupt while a host write to location 0 changes the enable or clears the flag. The bench forces this collision directly: once with enable 1 and a clearing write, where the flag must stay low, and once with enable 0 and a write that sets it, where the old enable rules and the flag stays low. Random runs then put events and writes in the same cycle many more times. Every cycle, the flag is judged against a bench model in which the write has priority and the set uses the enable as it stood before the edge.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_JOY = 3'd0;
  localparam logic [OFF_W-1:0] OFF_EE  = 3'd1;

  // location 0 fields
  localparam int RATE_LSB = 0;
  localparam int XTAL_BIT = 3;
  localparam int CSW_BIT  = 5;
  // location 1 fields
  localparam int CLK_BIT  = 0;
  localparam int DOUT_BIT = 1;
  localparam int EN_BIT   = 2;
  localparam int POL_BIT  = 7;

  typedef struct packed {
    logic [1:0] rate;
    logic       xtal;
    logic       csw_en;
  } joy_t;

  typedef struct packed {
    logic pol;
    logic een;
    logic dout;
    logic clk;
  } ee_t;
endpackage

// File: rtl/ctrl_addr_decode.sv
module ctrl_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 12,
  parameter int OFF_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DEC_W-1:0]  base_addr,
  output logic              hit,
  output logic [OFF_W-1:0]  offset
);
  logic upper_ok;

  generate
    if (ADDR_W > DEC_W) begin : g_upper
      assign upper_ok = (addr[ADDR_W-1:DEC_W] == '0);
    end else begin : g_no_upper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign hit    = upper_ok && (addr[DEC_W-1:OFF_W] == base_addr[DEC_W-1:OFF_W]);
  assign offset = addr[OFF_W-1:0];
endmodule

// File: rtl/ctrl_joy_regs.sv
module ctrl_joy_regs
  import ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cs_event,
  output joy_t              q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.rate   <= 2'b01;
      q.xtal   <= 1'b0;
      q.csw_en <= 1'b0;
    end else if (wr) begin
      q.rate   <= wdata[RATE_LSB +: 2];
      q.xtal   <= wdata[XTAL_BIT];
      q.csw_en <= wdata[CSW_BIT];
    end
  end

  // write with enable cleared wins over a same-cycle event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (wr && !wdata[CSW_BIT])  irq <= 1'b0;
    else if (cs_event && q.csw_en)   irq <= 1'b1;
  end
endmodule

// File: rtl/ctrl_ee_port.sv
module ctrl_ee_port
  import ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_i,
  output ee_t               q,
  output logic [DATA_W-1:0] rd_val,
  output logic              scl_o,
  output logic              scl_oe,
  output logic              sda_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.pol  <= 1'b1;
      q.een  <= 1'b0;
      q.dout <= 1'b0;
      q.clk  <= 1'b0;
    end else if (wr) begin
      q.pol  <= wdata[POL_BIT];
      q.een  <= wdata[EN_BIT];
      q.dout <= wdata[DOUT_BIT];
      q.clk  <= wdata[CLK_BIT];
    end
  end

  assign scl_oe = q.een;
  assign scl_o  = q.clk;
  assign sda_oe = q.een & ~q.dout;

  always_comb begin
    rd_val           = '0;
    rd_val[POL_BIT]  = q.pol;
    rd_val[EN_BIT]   = sda_i;
    rd_val[DOUT_BIT] = q.dout;
    rd_val[CLK_BIT]  = q.clk;
  end
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEC_W-1:0]  base_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cs_event,
  output logic              host_irq,
  output logic [1:0]        joy_rate,
  output logic              xtal_off,
  input  logic              ee_sda_i,
  output logic              ee_scl_o,
  output logic              ee_scl_oe,
  output logic              ee_sda_oe,
  input  logic              cd_int_req,
  output logic              cd_int_out
);
  logic             hit;
  logic [OFF_W-1:0] offset;
  joy_t             joy_q;
  ee_t              ee_q;
  logic [DATA_W-1:0] ee_rd;
  logic             joy_wr, ee_wr;

  ctrl_addr_decode #(.ADDR_W(ADDR_W), .DEC_W(DEC_W), .OFF_W(OFF_W)) u_dec (
    .addr(addr), .base_addr(base_addr), .hit(hit), .offset(offset)
  );

  assign joy_wr = wr_en && hit && (offset == OFF_JOY);
  assign ee_wr  = wr_en && hit && (offset == OFF_EE) && !joy_q.xtal;

  ctrl_joy_regs u_joy (
    .clk(clk), .rst_n(rst_n), .wr(joy_wr), .wdata(wdata),
    .cs_event(cs_event), .q(joy_q), .irq(host_irq)
  );

  ctrl_ee_port u_ee (
    .clk(clk), .rst_n(rst_n), .wr(ee_wr), .wdata(wdata), .sda_i(ee_sda_i),
    .q(ee_q), .rd_val(ee_rd), .scl_o(ee_scl_o), .scl_oe(ee_scl_oe),
    .sda_oe(ee_sda_oe)
  );

  assign joy_rate   = joy_q.rate;
  assign xtal_off   = joy_q.xtal;
  assign cd_int_out = ee_q.pol ? cd_int_req : ~cd_int_req;

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      case (offset)
        OFF_JOY: begin
          rdata[RATE_LSB +: 2] = joy_q.rate;
          rdata[XTAL_BIT]      = joy_q.xtal;
          rdata[CSW_BIT]       = joy_q.csw_en;
        end
        OFF_EE:  rdata = joy_q.xtal ? '0 : ee_rd;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctrl_regbank_chk.sv
module ctrl_regbank_chk #(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DEC_W-1:0]  base_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              cs_event,
  input logic              host_irq,
  input logic [1:0]        joy_rate,
  input logic              xtal_off,
  input logic              ee_sda_i,
  input logic              ee_scl_o,
  input logic              ee_scl_oe,
  input logic              ee_sda_oe,
  input logic              cd_int_req,
  input logic              cd_int_out
);
  logic bus_hit, clr_wr, ee_loc;
  assign bus_hit = (addr[ADDR_W-1:DEC_W] == '0) && (addr[DEC_W-1:3] == base_addr[DEC_W-1:3]);
  assign clr_wr  = wr_en && bus_hit && (addr[2:0] == 3'd0) && !wdata[5];
  assign ee_loc  = bus_hit && (addr[2:0] == 3'd1);

  // R12
  miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bus_hit) |-> (rdata == 8'h00));

  // R2
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_hit && addr[2:1] != 2'b00) |-> (rdata == 8'h00));

  // R9
  sda_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sda_oe |-> ee_scl_oe);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !host_irq);

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !clr_wr) |=> host_irq);

  // R4
  locked_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtal_off && wr_en && ee_loc) |=> ($stable(ee_scl_o) && $stable(ee_scl_oe) && $stable(ee_sda_oe)));

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtal_off && rd_en && ee_loc) |-> (rdata == 8'h00));

  // R11
  cd_pol_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cd_int_req) && !$stable(cd_int_out)) |-> $past(wr_en));
endmodule

bind ctrl_regbank ctrl_regbank_chk #(.ADDR_W(ADDR_W), .DEC_W(DEC_W)) u_chk (.*);

// File: tb/ctrl_regbank_bench.sv
module ctrl_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] base_addr = 12'h200;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        cs_event = 1'b0;
  logic        host_irq;
  logic [1:0]  joy_rate;
  logic        xtal_off;
  logic        ee_sda_i = 1'b1;
  logic        ee_scl_o, ee_scl_oe, ee_sda_oe;
  logic        cd_int_req = 1'b0;
  logic        cd_int_out;

  always #10 clk = ~clk;

  ctrl_regbank u_ctrl_regbank (.*);

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  // bench model
  logic [1:0] m_rate;
  logic m_xtal, m_csw, m_irq, m_clk, m_dout, m_een, m_pol;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic hit_f(logic [15:0] a);
    return (a[15:12] == 4'h0) && (a[11:3] == base_addr[11:3]);
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (!hit_f(a)) return 8'h00;
    case (a[2:0])
      3'd0: return {2'b00, m_csw, 1'b0, m_xtal, 1'b0, m_rate};
      3'd1: return m_xtal ? 8'h00 : {m_pol, 4'b0000, ee_sda_i, m_dout, m_clk};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(logic [15:0] a);
    if (!hit_f(a)) return "R1 R12";
    case (a[2:0])
      3'd0: return "R3";
      3'd1: return m_xtal ? "R4" : "R7 R10";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_rate = 2'b01; m_xtal = 0; m_csw = 0; m_irq = 0;
    m_clk = 0; m_dout = 0; m_een = 0; m_pol = 1;
  endtask

  task automatic step(logic w, logic r, logic [15:0] a, logic [7:0] d, logic ev);
    logic old_csw;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; cs_event = ev;
    ee_sda_i = 1'($urandom); cd_int_req = 1'($urandom);
    #2;
    if (r) chk(rd_tag(a), rdata, exp_rd(a));
    chk("R8", {6'b0, ee_scl_oe, ee_scl_o}, {6'b0, m_een, m_clk});
    chk("R9", {7'b0, ee_sda_oe}, {7'b0, m_een & ~m_dout});
    chk("R5", {7'b0, host_irq}, {7'b0, m_irq});
    chk("R3", {5'b0, xtal_off, joy_rate}, {5'b0, m_xtal, m_rate});
    chk("R11", {7'b0, cd_int_out}, {7'b0, m_pol ? cd_int_req : ~cd_int_req});
    @(posedge clk);
    #1;
    old_csw = m_csw;
    if (w && hit_f(a) && a[2:0] == 3'd0) begin
      m_rate = d[1:0]; m_xtal = d[3]; m_csw = d[5];
    end
    if (w && hit_f(a) && a[2:0] == 3'd1 && !m_xtal) begin
      m_pol = d[7]; m_een = d[2]; m_dout = d[1]; m_clk = d[0];
    end
    if (w && hit_f(a) && a[2:0] == 3'd0 && !d[5]) m_irq = 1'b0;  // R6
    else if (ev && old_csw) m_irq = 1'b1;                         // R5
  endtask

  function automatic logic [15:0] blk(logic [2:0] off);
    return {4'h0, base_addr[11:3], off};
  endfunction

  initial begin : watchdog
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_C0DE));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset values R3 R7
    step(0, 1, blk(0), 0, 0);
    step(0, 1, blk(1), 0, 0);
    // R2 unused locations: write then read back zero
    for (int i = 2; i < 8; i++) step(1, 0, blk(3'(i)), 8'hFF, 0);
    for (int i = 2; i < 8; i++) step(0, 1, blk(3'(i)), 0, 0);
    step(0, 1, blk(0), 0, 0);
    // R1 R12 miss: upper bits set and neighbouring window
    step(1, 0, 16'h1000 | blk(0), 8'h2B, 0);
    step(1, 0, blk(0) + 16'h0008, 8'h2B, 0);
    step(0, 1, 16'h1000 | blk(1), 0, 0);
    step(0, 1, blk(0), 0, 0);
    // R8 R9 R10: drive enable, data low, clock high; then release
    step(1, 0, blk(1), 8'h85, 0);
    step(0, 1, blk(1), 0, 0);
    step(1, 0, blk(1), 8'h07, 0);
    step(0, 1, blk(1), 0, 0);
    // R8: enable off, clock bit still stored
    step(1, 0, blk(1), 8'h01, 0);
    step(0, 1, blk(1), 0, 0);
    // R5: event while disabled has no effect, then enabled sets flag
    step(0, 0, blk(0), 0, 1);
    step(1, 0, blk(0), 8'h20, 1);   // same-cycle enable write: old enable 0 rules
    step(0, 0, blk(0), 0, 0);
    step(0, 0, blk(0), 0, 1);
    step(0, 0, blk(0), 0, 0);
    // R6 collision: clearing write and event together
    step(1, 0, blk(0), 8'h03, 1);
    step(0, 1, blk(0), 0, 0);
    // R4 power-down lock
    step(1, 0, blk(1), 8'h06, 0);
    step(1, 0, blk(0), 8'h0A, 0);
    step(1, 0, blk(1), 8'h79, 0);
    step(0, 1, blk(1), 0, 0);
    step(0, 1, blk(0), 0, 0);
    step(1, 0, blk(0), 8'h02, 0);
    step(0, 1, blk(1), 0, 0);
    // R11 polarity low
    step(1, 0, blk(1), 8'h00, 0);
    step(0, 0, blk(0), 0, 0);
    step(0, 0, blk(0), 0, 0);
    // R1: base with nonzero low bits
    base_addr = 12'h22B;
    step(1, 0, 16'h0228, 8'h03, 0);
    step(0, 1, 16'h0228, 0, 0);
    step(0, 1, 16'h022B, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom % 8);
      if (sel < 6) a = blk(($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 2));
      else if (sel == 6) a = blk(3'($urandom)) | 16'(($urandom % 15 + 1) << 12);
      else a = {4'h0, 12'($urandom)};
      if (n == 1500) base_addr = 12'($urandom);
      step(1'($urandom), 1'($urandom), a, 8'($urandom), ($urandom % 3) == 0);
    end

    @(negedge clk);
    wr_en = 0; rd_en = 0; cs_event = 0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule